// File: doc/BRIEF.md
# Single-Precision to Minifloat Converter

This block turns a 32-bit IEEE-754 single-precision word into a narrow floating-point word whose exponent width and mantissa width are parameters. The intended configurations are an 8-bit word (4 exponent bits, 3 mantissa bits), a 12-bit word (5 and 6) and a 16-bit word (5 and 10). A value is presented with a valid strobe, and the packed result appears on the output register one clock later with its own valid flag. It suits storing weights and activations of a neural-network datapath in reduced precision.

The conversion keeps the sign and rebiases the exponent to the narrow format. It rounds the truncated fraction, and a rounding carry out of the mantissa bumps the exponent. Values too small for a normal encoding are denormalised with a one-bit correction. Values too large saturate to a signed infinity. Input infinities and NaNs become a signed infinity, and input zeros and single-precision subnormals become a signed zero.

Top module: `fp32_to_minifloat`

## Requirements
- R1: The output word is packed with the sign in its top bit, then EXP_W exponent bits, then MAN_W mantissa bits in the least significant positions. The sign is always bit 31 of the input.
- R2: out_valid equals in_valid of the previous clock. A synchronous active-low reset forces out_valid and out_data to zero, and it overrides in_valid.
- R3: Let D = 23-MAN_W. The guard bit is input bit D-1, the last kept bit is bit D, the round bit is bit D-2, and the sticky bit is the OR of bits D-3..0. The kept mantissa is bits 22..D, and it is incremented exactly when guard AND (last OR round OR sticky).
- R4: When that increment carries out of the mantissa, the mantissa field becomes zero and the exponent rises by one.
- R5: The exponent value is (input exponent - 127) + (2^(EXP_W-1) - 1) + carry. When this value lies in 1..2^EXP_W-2, it is written to the exponent field together with the rounded mantissa.
- R6: When the exponent value is 2^EXP_W-1 or larger, the output is infinity of the input sign: exponent field all ones, mantissa zero.
- R7: An input exponent of 255 (infinity or NaN) gives infinity of the input sign.
- R8: An input exponent of 0 (zero or single-precision subnormal) gives a zero of the input sign.
- R9: When the exponent value e is 0 or less, the shift is k = 1-e. The (MAN_W+1)-bit value {1, rounded mantissa} is shifted right by k, and the most significant bit shifted out is added. The sum is written zero-extended into the exponent and mantissa fields, so a carry lands in the exponent LSB.
- R10: When k exceeds MAN_W+1, the output is a zero of the input sign.
- R11: While in_valid is low, out_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 32 | Single-precision input value |
| out_valid | output | 1 | out_data was updated from a valid input |
| out_data | output | 1+EXP_W+MAN_W | Packed sign, exponent and mantissa |

## Verification
The hardest cases to reach are the ones where two corrections stack. The first is a denormal whose one-bit correction carries into the exponent field. The second is a rounding carry that lifts an underflowing value back to normal or pushes the largest finite value into infinity. Directed vectors place the input exponent at the exact edges for the default 8-bit format: denormal shifts of 1, MAN_W+1 and MAN_W+2, all-ones mantissas with the guard set, and the top two normal exponents. A sweep over all 256 input exponents with boundary fractions and a pseudo-random word stream then cover the remaining combinations against the behavioural model.

// File: rtl/fp2mf_pkg.sv
// Shared definitions for the single-precision to minifloat converter.
// Assumes the input follows the IEEE-754 binary32 layout.
package fp2mf_pkg;
    localparam int FP32_FRAC_W = 23;
    localparam int FP32_EXP_W  = 8;
    localparam int FP32_BIAS   = 127;

    typedef struct packed {
        logic                   sign;
        logic [FP32_EXP_W-1:0]  expo;
        logic [FP32_FRAC_W-1:0] frac;
    } fp32_t;
endpackage

// File: rtl/mfc_round.sv
// Mantissa rounding stage: keeps the top MAN_W fraction bits and adds one
// when guard AND (last OR round OR sticky). Reports a carry out of the
// mantissa. Assumes MAN_W <= 20 so that at least three bits are discarded.
module mfc_round
    import fp2mf_pkg::*;
#(
    parameter int MAN_W = 3
) (
    input  logic [FP32_FRAC_W-1:0] frac,
    output logic [MAN_W-1:0]       man,
    output logic                   carry
);
    localparam int DROP = FP32_FRAC_W - MAN_W;

    logic           guard_b, last_b, round_b, sticky_b, inc;
    logic [MAN_W:0] sum;

    // Pick the rounding bits and form the increment (R3)
    always_comb begin
        guard_b  = frac[DROP-1];
        last_b   = frac[DROP];
        round_b  = frac[DROP-2];
        sticky_b = |frac[DROP-3:0];
        inc      = guard_b & (last_b | round_b | sticky_b);
        sum      = {1'b0, frac[FP32_FRAC_W-1:DROP]} + {{MAN_W{1'b0}}, inc};
        man      = sum[MAN_W-1:0];
        carry    = sum[MAN_W];
    end

    // R4: a carry out can only come from an all-ones mantissa, leaving zeros
    always_comb begin
        a_r4_carry_zero_man: assert (!(carry && (man != '0)))
            else $error("R4: carry with nonzero mantissa");
    end
endmodule

// File: rtl/mfc_exp.sv
// Exponent rebias stage: converts the biased single-precision exponent to
// the minifloat bias, adds the rounding carry, and classifies the result as
// overflowing or underflowing. Assumes EXP_W <= 8.
module mfc_exp
    import fp2mf_pkg::*;
#(
    parameter int EXP_W = 4
) (
    input  logic [FP32_EXP_W-1:0] expo_in,
    input  logic                  carry,
    output logic signed [10:0]    expo_val,
    output logic                  too_big,
    output logic                  too_small
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [10:0] OFFSET = 11'(BIAS - FP32_BIAS);
    localparam logic signed [10:0] EMAX   = 11'((1 << EXP_W) - 1);

    // Rebias and classify the exponent (R5, R6, R9)
    always_comb begin
        expo_val  = $signed({3'b000, expo_in}) + $signed({10'd0, carry}) + OFFSET;
        too_big   = expo_val >= EMAX;
        too_small = expo_val <= 11'sd0;
    end
endmodule

// File: rtl/mfc_denorm.sv
// Denormalisation stage: for an exponent value of zero or below, shifts the
// mantissa with its hidden one right by (1 - exponent) and adds the first
// bit shifted out. Flags a flush to zero when the shift passes MAN_W+1.
module mfc_denorm #(
    parameter int EXP_W = 4,
    parameter int MAN_W = 3
) (
    input  logic [MAN_W-1:0]       man,
    input  logic signed [10:0]     expo_val,
    output logic [EXP_W+MAN_W-1:0] field,
    output logic                   flush
);
    localparam int FW = EXP_W + MAN_W;

    logic signed [10:0] shift;
    logic [MAN_W:0]     full, res;

    // Select one of the MAN_W+1 legal shift amounts (R9, R10)
    always_comb begin
        shift = 11'sd1 - expo_val;
        full  = {1'b1, man};
        flush = shift > 11'(MAN_W + 1);
        res   = '0;
        for (int k = 1; k <= MAN_W + 1; k++) begin
            if (shift == 11'(k)) begin
                res = (full >> k) + {{MAN_W{1'b0}}, full[k-1]};
            end
        end
        field = {{(FW - MAN_W - 1){1'b0}}, res};
    end

    // R9: the corrected value never passes the smallest normal encoding
    always_comb begin
        a_r9_no_wrap: assert (!(res[MAN_W] && (res[MAN_W-1:0] != '0)))
            else $error("R9: denormal result above smallest normal");
    end
endmodule

// File: rtl/fp32_to_minifloat.sv
// Single-precision to minifloat converter, one register stage.
// Rounds, rebiases, denormalises and saturates in one combinational pass
// and registers the packed result when in_valid is high. Assumes
// 2 <= EXP_W <= 8 and 1 <= MAN_W <= 20. Reset is synchronous, active low.
module fp32_to_minifloat
    import fp2mf_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int MAN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [31:0]            in_data,
    output logic                   out_valid,
    output logic [EXP_W+MAN_W:0]   out_data
);
    localparam int OUT_W = 1 + EXP_W + MAN_W;
    localparam int FW    = EXP_W + MAN_W;

    fp32_t              in_w;
    logic [MAN_W-1:0]   rnd_man;
    logic               rnd_carry;
    logic signed [10:0] expo_val;
    logic               too_big, too_small, flush;
    logic [FW-1:0]      sub_field;
    logic [FW-1:0]      mag;
    logic [OUT_W-1:0]   next_word;

    assign in_w = in_data;

    mfc_round #(.MAN_W(MAN_W)) u_round (
        .frac  (in_w.frac),
        .man   (rnd_man),
        .carry (rnd_carry)
    );

    mfc_exp #(.EXP_W(EXP_W)) u_exp (
        .expo_in   (in_w.expo),
        .carry     (rnd_carry),
        .expo_val  (expo_val),
        .too_big   (too_big),
        .too_small (too_small)
    );

    mfc_denorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_denorm (
        .man      (rnd_man),
        .expo_val (expo_val),
        .field    (sub_field),
        .flush    (flush)
    );

    // Choose between special, saturated, denormal and normal results
    always_comb begin
        if (in_w.expo == '1) begin
            mag = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (in_w.expo == '0) begin
            mag = '0;
        end else if (too_big) begin
            mag = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (too_small) begin
            mag = flush ? '0 : sub_field;
        end else begin
            mag = {expo_val[EXP_W-1:0], rnd_man};
        end
        next_word = {in_w.sign, mag};
    end

    // Output register with one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_word;
            end
        end
    end

    // R2: valid follows the input strobe by one clock
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: sign bit carried from the input
    a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data[OUT_W-1] == $past(in_data[31]));

    // R7: infinity or NaN input saturates to infinity
    a_r7_special_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:23] == 8'hFF) |=>
            out_data[FW-1:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}});

    // R8: zero-exponent input gives signed zero
    a_r8_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:23] == 8'h00) |=> out_data[FW-1:0] == '0);

    // R11: output word held while no input is presented
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: tb/tb_fp32_to_minifloat.sv
// Self-checking bench: behavioural integer model, compared on every clock.
module tb_fp32_to_minifloat;
    localparam int EXP_W = 4;
    localparam int MAN_W = 3;
    localparam int OUT_W = 1 + EXP_W + MAN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_data = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    int               vectors = 0;
    int               miscompares = 0;
    logic             exp_valid = 1'b0;
    logic [OUT_W-1:0] exp_word = '0;
    string            pend_tag = "R2 reset";
    logic [31:0]      lfsr = 32'h1234_5678;

    always #4 clk = ~clk;

    fp32_to_minifloat #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Behavioural model built from the requirements with integer arithmetic
    function automatic logic [OUT_W-1:0] ref_conv(input logic [31:0] x);
        int ef, fr, sh, kept, rem, half, mm, em, d, full, q, g, bias, emax;
        bit rnd, o;
        logic [OUT_W-2:0] mag;
        sh   = 23 - MAN_W;
        bias = (1 << (EXP_W - 1)) - 1;
        emax = (1 << EXP_W) - 1;
        ef   = int'(x[30:23]);
        fr   = int'(x[22:0]);
        if (ef == 255) begin
            mag = (OUT_W-1)'(emax * (1 << MAN_W));
        end else if (ef == 0) begin
            mag = '0;
        end else begin
            kept = fr >> sh;
            rem  = fr % (1 << sh);
            half = 1 << (sh - 1);
            rnd  = (rem >= half) && ((kept % 2 == 1) || (rem != half));
            mm   = kept + int'(rnd);
            o    = mm >= (1 << MAN_W);
            if (o) mm = mm - (1 << MAN_W);
            em = ef - 127 + bias + int'(o);
            if (em >= emax) begin
                mag = (OUT_W-1)'(emax * (1 << MAN_W));
            end else if (em >= 1) begin
                mag = (OUT_W-1)'(em * (1 << MAN_W) + mm);
            end else begin
                d    = 1 - em;
                full = mm + (1 << MAN_W);
                if (d > MAN_W + 1) begin
                    mag = '0;
                end else begin
                    q   = full >> d;
                    g   = (full >> (d - 1)) % 2;
                    mag = (OUT_W-1)'(q + g);
                end
            end
        end
        return {x[31], mag};
    endfunction

    task automatic compare();
        vectors++;
        if (out_valid !== exp_valid || out_data !== exp_word) begin
            miscompares++;
            $display("FAIL %s: got valid=%b word=%h, expected valid=%b word=%h",
                     pend_tag, out_valid, out_data, exp_valid, exp_word);
        end
    endtask

    // One clock: check what the last drive produced, then drive anew
    task automatic step(input logic v, input logic [31:0] x, input string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        in_data  = x;
        exp_valid = v;
        if (v) exp_word = ref_conv(x);
        pend_tag = tag;
    endtask

    // Directed check with a hand-computed expectation, then model agreement
    task automatic known(input logic [31:0] x, input logic [OUT_W-1:0] want,
                         input string tag);
        vectors++;
        if (ref_conv(x) !== want) begin
            miscompares++;
            $display("FAIL %s model: got %h expected %h", tag, ref_conv(x), want);
        end
        step(1'b1, x, tag);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        miscompares++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R2: reset dominates a valid input
        in_valid = 1'b1;
        in_data  = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        in_valid = 1'b0;
        exp_valid = 1'b0;
        exp_word = '0;
        pend_tag = "R2 after reset";

        // R1 R5: plain normal values
        known(32'h3F80_0000, 8'h38, "R5 one");
        known(32'hBFC0_0000, 8'hBC, "R1 R5 minus one-and-half");
        // R3: rounding decisions
        known(32'h3F88_0000, 8'h38, "R3 guard only, tie to even");
        known(32'h3F88_0001, 8'h39, "R3 guard with sticky");
        known(32'h3F98_0000, 8'h3A, "R3 guard with last");
        known(32'h3F8C_0000, 8'h39, "R3 guard with round");
        // R4: carry renormalises
        known(32'h3FF8_0000, 8'h40, "R4 carry into exponent");
        // R6: saturation
        known(32'h4300_0000, 8'h70, "R6 largest exponent stays finite");
        known(32'h4380_0000, 8'h78, "R6 overflow to infinity");
        known(32'hC37C_0000, 8'hF8, "R4 R6 carry into infinity negative");
        // R7 R8: special inputs
        known(32'h7F80_0000, 8'h78, "R7 infinity");
        known(32'hFFC0_0001, 8'hF8, "R7 NaN to negative infinity");
        known(32'h8000_0000, 8'h80, "R8 negative zero");
        known(32'h0000_0001, 8'h00, "R8 input subnormal");
        // R9 R10: denormalisation
        known(32'h3C00_0000, 8'h04, "R9 shift by one");
        known(32'h3B00_0000, 8'h01, "R9 shift by three");
        known(32'h3A80_0000, 8'h01, "R9 shift by MAN_W+1");
        known(32'h3C70_0000, 8'h08, "R9 correction carries to exponent");
        known(32'h3C78_0000, 8'h08, "R4 R9 rounding lifts to normal");
        known(32'h3A00_0000, 8'h00, "R10 shift past MAN_W+1");
        known(32'hBA00_0000, 8'h80, "R10 negative flush");
        // R11: hold while idle
        step(1'b0, 32'h4000_0000, "R11 hold idle");
        step(1'b0, 32'hC000_0000, "R11 hold idle again");

        // R2: reset in mid-run with a valid input
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_data = 32'h3F80_0000;
        exp_valid = 1'b0;
        exp_word = '0;
        pend_tag = "R2 mid-run reset";
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        in_valid = 1'b0;
        pend_tag = "R2 after mid-run reset";

        // R3 R5 R6 R9: sweep every input exponent with boundary fractions
        for (int e = 0; e < 256; e++) begin
            step(1'b1, {e[0], e[7:0], 23'h000000}, "R5 sweep");
            step(1'b1, {e[1], e[7:0], 23'h780000}, "R4 sweep");
            step(1'b1, {e[2], e[7:0], 23'h080001}, "R3 sweep");
            step(e[0], {e[3], e[7:0], 23'h7FFFFF}, "R11 sweep");
        end

        // R9 mixed: pseudo-random stream around the small exponents
        for (int i = 0; i < 600; i++) begin
            lfsr ^= lfsr << 13;
            lfsr ^= lfsr >> 17;
            lfsr ^= lfsr << 5;
            if (i % 2 == 0)
                step(1'b1, {lfsr[31], 3'b011, lfsr[27:0]}, "R9 random small");
            else
                step(lfsr[3] | lfsr[7], lfsr, "R1 random");
        end
        step(1'b0, 32'h0, "R2 final idle");
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule